// File: doc/BRIEF.md
# Configuration Register Local-Access Arbiter

This block lets application logic read and write 32-bit configuration registers through a side-band port. The same register file also serves a link-side configuration request path. A local access starts with a one-cycle read or write enable, together with a 12-bit byte address, a 9-bit target selector and write data. The block keeps the request in a single holding slot and runs it only in a cycle when the link side presents no request. It then reports completion with a one-cycle acknowledge, which also qualifies the read data.

Each access goes either to a base register bank or to one of several per-function banks. Selector bit 8 picks between them, and selector bits [7:0] give the function number. Both paths write through the same per-bit writable masks, so read-only bits behave the same whichever side writes them. In this project, simple behavioural banks stand in for the real register contents. Base register i resets to {8'h5A, i[7:0], 16'h0000}. Register i of function f resets to {8'hC0|f, i[7:0], 16'h0000}. In every bank, register 0 is fully read-only, and in the other registers only bits [15:0] are writable.

Top module: `cfgacc_arbiter`

## Requirements
- R1: After reset, loc_ack and link_rvalid are low, and every register holds its reset value as defined above.
- R2: A local read whose enable is sampled at clock edge E, with link_req low at edge E+1, executes at E+1. loc_ack is then high in the cycle after E+1, and loc_rdata carries the register value in that same cycle.
- R3: While link_req is high, a held local access does not execute. It executes at the first edge at which link_req is low, and loc_ack follows in the next cycle.
- R4: loc_ack is high for exactly one cycle per completed local access.
- R5: Address bits [1:0] are ignored. The word index is address bits [11:2].
- R6: When selector bit 8 is 0, the access reaches the base bank whatever bits [7:0] hold. When bit 8 is 1, it reaches the function bank numbered by bits [7:0].
- R7: A write changes only the bits of its register's writable mask. This holds the same way for local and link-side writes.
- R8: If loc_rd and loc_wr are high in the same cycle, the read is performed and the write is discarded.
- R9: Only one local request is outstanding at a time. Enables that arrive while a request is held are ignored and produce no extra acknowledge.
- R10: A read of a word index beyond a bank, or of a function number with no bank, returns zero. A write to such a location changes no register.
- R11: A link read presented with link_req high and link_wr low gives link_rvalid high in the next cycle, with link_rdata holding the register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_req | input | 1 | Link-side access present this cycle |
| link_wr | input | 1 | Link-side access is a write |
| link_addr | input | 12 | Link-side byte address |
| link_sel | input | 9 | Link-side bank selector / function number |
| link_wdata | input | 32 | Link-side write data |
| link_rvalid | output | 1 | Link-side read data valid |
| link_rdata | output | 32 | Link-side read data |
| loc_rd | input | 1 | Local read enable |
| loc_wr | input | 1 | Local write enable |
| loc_addr | input | 12 | Local byte address |
| loc_sel | input | 9 | Local bank selector / function number |
| loc_wdata | input | 32 | Local write data |
| loc_ack | output | 1 | One-cycle local completion |
| loc_rdata | output | 32 | Local read data, valid with loc_ack |

## Verification
The bench builds the block with its default parameters: a 16-register base bank and four function banks of eight registers each. With these values, both out-of-range cases can be reached. Base index 40 lies past the bank, and if its upper address bits were dropped it would alias onto index 8. Function number 7 has no bank. Function banks 1 and 2 differ only in their tag byte, so a write that reached the wrong function, or the base bank, shows up in a later read.

// File: rtl/cfgacc_pkg.sv
package cfgacc_pkg;
  localparam int DW  = 32;
  localparam int AW  = 12;
  localparam int SW  = 9;
  localparam int IW  = AW - 2;

  typedef struct packed {
    logic          wr;
    logic [SW-1:0] sel;
    logic [IW-1:0] idx;
    logic [DW-1:0] wdata;
  } acc_t;

  function automatic logic [DW-1:0] reg_init(input logic [7:0] tag, input int i);
    return {tag, 8'(i), 16'h0000};
  endfunction

  function automatic logic [DW-1:0] reg_wmask(input int i);
    return (i == 0) ? 32'h0000_0000 : 32'h0000_FFFF;
  endfunction
endpackage

// File: rtl/cfgacc_regbank.sv
module cfgacc_regbank
  import cfgacc_pkg::*;
#(
  parameter int          NREGS = 16,
  parameter logic [7:0]  TAG   = 8'h5A,
  localparam int         XW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [NREGS-1:0][DW-1:0] regs;
  logic                     in_range;

  assign in_range = (32'(idx) < 32'(NREGS));

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam logic [DW-1:0] INIT = reg_init(TAG, i);
    localparam logic [DW-1:0] MASK = reg_wmask(i);
    logic [DW-1:0] q;
    logic [DW-1:0] q_nx;
    logic          hit;

    assign hit = wr_en && (idx == IW'(i));

    always_comb begin
      q_nx = q;
      if (hit) q_nx = (q & ~MASK) | (wr_data & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= INIT;
      else if (hit) q <= q_nx;
    end

    assign regs[i] = q;
  end

  assign rd_data = in_range ? regs[idx[XW-1:0]] : '0;
endmodule

// File: rtl/cfgacc_hold.sv
module cfgacc_hold
  import cfgacc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic          pend,
  output acc_t          held
);
  logic pend_nx;
  logic cap;
  acc_t held_nx;

  assign cap = !pend && (rd || wr);

  always_comb begin
    pend_nx = pend;
    if (cap)       pend_nx = 1'b1;
    else if (take) pend_nx = 1'b0;
    held_nx.wr    = wr && !rd;
    held_nx.sel   = sel;
    held_nx.idx   = addr[AW-1:2];
    held_nx.wdata = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= '0;
    else if (cap) held <= held_nx;
  end
endmodule

// File: rtl/cfgacc_arbiter.sv
module cfgacc_arbiter
  import cfgacc_pkg::*;
#(
  parameter int  NUM_BASE  = 16,
  parameter int  NUM_FUNC  = 4,
  parameter int  FUNC_REGS = 8,
  localparam int FXW       = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_req,
  input  logic          link_wr,
  input  logic [AW-1:0] link_addr,
  input  logic [SW-1:0] link_sel,
  input  logic [DW-1:0] link_wdata,
  output logic          link_rvalid,
  output logic [DW-1:0] link_rdata,
  input  logic          loc_rd,
  input  logic          loc_wr,
  input  logic [AW-1:0] loc_addr,
  input  logic [SW-1:0] loc_sel,
  input  logic [DW-1:0] loc_wdata,
  output logic          loc_ack,
  output logic [DW-1:0] loc_rdata
);
  logic                        loc_pend;
  acc_t                        held;
  logic                        loc_go;
  logic                        link_rd_go;
  logic                        acc_we;
  logic [SW-1:0]               acc_sel;
  logic [IW-1:0]               acc_idx;
  logic [DW-1:0]               acc_wdata;
  logic [DW-1:0]               base_rd;
  logic [NUM_FUNC-1:0][DW-1:0] func_rd;
  logic                        func_ok;
  logic [DW-1:0]               rd_mux;
  logic                        ack_nx;
  logic [DW-1:0]               loc_rdata_nx;
  logic                        rvalid_nx;
  logic [DW-1:0]               link_rdata_nx;

  cfgacc_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (loc_rd),
    .wr    (loc_wr),
    .addr  (loc_addr),
    .sel   (loc_sel),
    .wdata (loc_wdata),
    .take  (loc_go),
    .pend  (loc_pend),
    .held  (held)
  );

  // link side owns the bank whenever it presents a request
  assign loc_go     = loc_pend && !link_req;
  assign link_rd_go = link_req && !link_wr;

  always_comb begin
    if (link_req) begin
      acc_sel   = link_sel;
      acc_idx   = link_addr[AW-1:2];
      acc_wdata = link_wdata;
      acc_we    = link_wr;
    end else begin
      acc_sel   = held.sel;
      acc_idx   = held.idx;
      acc_wdata = held.wdata;
      acc_we    = loc_go && held.wr;
    end
  end

  cfgacc_regbank #(.NREGS(NUM_BASE), .TAG(8'h5A)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_we && !acc_sel[SW-1]),
    .idx     (acc_idx),
    .wr_data (acc_wdata),
    .rd_data (base_rd)
  );

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
    cfgacc_regbank #(.NREGS(FUNC_REGS), .TAG(8'hC0 | 8'(f))) u_fn (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc_we && acc_sel[SW-1] && (acc_sel[SW-2:0] == 8'(f))),
      .idx     (acc_idx),
      .wr_data (acc_wdata),
      .rd_data (func_rd[f])
    );
  end

  assign func_ok = (32'(acc_sel[SW-2:0]) < 32'(NUM_FUNC));

  always_comb begin
    if (!acc_sel[SW-1]) rd_mux = base_rd;
    else if (func_ok)   rd_mux = func_rd[acc_sel[FXW-1:0]];
    else                rd_mux = '0;
  end

  always_comb begin
    ack_nx        = loc_go;
    loc_rdata_nx  = (loc_go && !held.wr) ? rd_mux : loc_rdata;
    rvalid_nx     = link_rd_go;
    link_rdata_nx = link_rd_go ? rd_mux : link_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_ack     <= 1'b0;
      loc_rdata   <= '0;
      link_rvalid <= 1'b0;
      link_rdata  <= '0;
    end else begin
      loc_ack     <= ack_nx;
      loc_rdata   <= loc_rdata_nx;
      link_rvalid <= rvalid_nx;
      link_rdata  <= link_rdata_nx;
    end
  end
endmodule

// File: rtl/cfgacc_arbiter_chk.sv
module cfgacc_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic link_req,
  input logic link_wr,
  input logic loc_ack,
  input logic link_rvalid,
  input logic pend
);
  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ack |=> !loc_ack);

  // R3
  ack_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ack |-> !$past(link_req));

  // R3
  held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && link_req) |=> pend);

  // R2
  ack_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ack |-> $past(pend));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (pend || loc_ack));

  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_rvalid |-> $past(link_req && !link_wr));
endmodule

bind cfgacc_arbiter cfgacc_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_req    (link_req),
  .link_wr     (link_wr),
  .loc_ack     (loc_ack),
  .link_rvalid (link_rvalid),
  .pend        (loc_pend)
);

// File: tb/cfgacc_arbiter_test.sv
module cfgacc_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_req, link_wr;
  logic [11:0] link_addr;
  logic [8:0]  link_sel;
  logic [31:0] link_wdata;
  logic        link_rvalid;
  logic [31:0] link_rdata;
  logic        loc_rd, loc_wr;
  logic [11:0] loc_addr;
  logic [8:0]  loc_sel;
  logic [31:0] loc_wdata;
  logic        loc_ack;
  logic [31:0] loc_rdata;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  cfgacc_arbiter uut (
    .clk(clk), .rst_n(rst_n),
    .link_req(link_req), .link_wr(link_wr), .link_addr(link_addr),
    .link_sel(link_sel), .link_wdata(link_wdata),
    .link_rvalid(link_rvalid), .link_rdata(link_rdata),
    .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_addr(loc_addr),
    .loc_sel(loc_sel), .loc_wdata(loc_wdata),
    .loc_ack(loc_ack), .loc_rdata(loc_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loc_op(input logic rd, input logic wr, input logic [11:0] a,
                        input logic [8:0] s, input logic [31:0] wd,
                        output logic [31:0] rdv, output int lat);
    @(negedge clk);
    loc_rd = rd; loc_wr = wr; loc_addr = a; loc_sel = s; loc_wdata = wd;
    @(negedge clk);
    loc_rd = 1'b0; loc_wr = 1'b0; lat = 0;
    while (!loc_ack && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    rdv = loc_rdata;
    @(negedge clk);
    chk("R4 ack single cycle", 32'(loc_ack), 32'd0);
  endtask

  task automatic lrd(input string req, input logic [11:0] a, input logic [8:0] s,
                     input logic [31:0] exp);
    logic [31:0] v;
    int lat;
    loc_op(1'b1, 1'b0, a, s, 32'd0, v, lat);
    chk(req, v, exp);
    chk("R2 ack latency", 32'(lat), 32'd1);
  endtask

  task automatic lwr(input logic [11:0] a, input logic [8:0] s, input logic [31:0] wd);
    logic [31:0] v;
    int lat;
    loc_op(1'b0, 1'b1, a, s, wd, v, lat);
    chk("R2 write ack latency", 32'(lat), 32'd1);
  endtask

  task automatic link_op(input logic wr, input logic [11:0] a, input logic [8:0] s,
                         input logic [31:0] wd, output logic [31:0] rdv);
    @(negedge clk);
    link_req = 1'b1; link_wr = wr; link_addr = a; link_sel = s; link_wdata = wd;
    @(negedge clk);
    link_req = 1'b0; link_wr = 1'b0;
    rdv = link_rdata;
    chk("R11 link rvalid", 32'(link_rvalid), 32'(!wr));
  endtask

  function automatic logic [31:0] base_v(input int i);
    return {8'h5A, 8'(i), 16'h0000};
  endfunction

  function automatic logic [31:0] fn_v(input int f, input int i);
    return {8'hC0 | 8'(f), 8'(i), 16'h0000};
  endfunction

  task automatic t_reset;
    chk("R1 loc_ack after reset", 32'(loc_ack), 32'd0);
    chk("R1 link_rvalid after reset", 32'(link_rvalid), 32'd0);
    lrd("R1 base reset value", 12'(3*4), 9'h000, base_v(3));
    lrd("R1 func reset value", 12'(5*4), 9'h103, fn_v(3, 5));
  endtask

  task automatic t_mask;
    lwr(12'(5*4), 9'h000, 32'hFFFF_1234);
    lrd("R7 writable low half", 12'(5*4), 9'h000, {8'h5A, 8'h05, 16'h1234});
    lwr(12'(0), 9'h000, 32'hFFFF_FFFF);
    lrd("R7 reg0 read-only", 12'(0), 9'h000, base_v(0));
  endtask

  task automatic t_addr_low;
    lrd("R5 low bits on read", 12'(5*4 + 3), 9'h000, {8'h5A, 8'h05, 16'h1234});
    lwr(12'(6*4 + 2), 9'h000, 32'h0000_00AB);
    lrd("R5 low bits on write", 12'(6*4), 9'h000, {8'h5A, 8'h06, 16'h00AB});
  endtask

  task automatic t_select;
    lrd("R6 base ignores fn bits", 12'(3*4), 9'h07F, base_v(3));
    lrd("R6 function 2", 12'(4*4), 9'h102, fn_v(2, 4));
    lwr(12'(2*4), 9'h101, 32'h0000_BEEF);
    lrd("R6 function 1 written", 12'(2*4), 9'h101, {8'hC1, 8'h02, 16'hBEEF});
    lrd("R6 function 2 untouched", 12'(2*4), 9'h102, fn_v(2, 2));
    lrd("R6 base untouched", 12'(2*4), 9'h000, base_v(2));
  endtask

  task automatic t_range;
    lrd("R10 base beyond bank", 12'(20*4), 9'h000, 32'd0);
    lrd("R10 missing function", 12'(1*4), 9'h107, 32'd0);
    lwr(12'(40*4), 9'h000, 32'h0000_5151);
    lrd("R10 no alias write", 12'(8*4), 9'h000, base_v(8));
  endtask

  task automatic t_priority;
    @(negedge clk);
    link_req = 1'b1; link_wr = 1'b0; link_addr = 12'(1*4); link_sel = 9'h000;
    loc_rd = 1'b1; loc_addr = 12'(9*4); loc_sel = 9'h000;
    @(negedge clk);
    loc_rd = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R3 held while link busy", 32'(loc_ack), 32'd0);
      if (k == 1) chk("R11 link read data", link_rdata, base_v(1));
      @(negedge clk);
    end
    link_req = 1'b0;
    @(negedge clk);
    chk("R3 served after link idle", 32'(loc_ack), 32'd1);
    chk("R3 read data", loc_rdata, base_v(9));
    @(negedge clk);
    chk("R4 ack drops", 32'(loc_ack), 32'd0);
  endtask

  task automatic t_link;
    logic [31:0] v;
    link_op(1'b1, 12'(7*4), 9'h000, 32'hFFFF_5555, v);
    lrd("R7 link write masked", 12'(7*4), 9'h000, {8'h5A, 8'h07, 16'h5555});
    link_op(1'b1, 12'(0), 9'h101, 32'hFFFF_FFFF, v);
    link_op(1'b0, 12'(0), 9'h101, 32'd0, v);
    chk("R7 link write reg0 read-only", v, fn_v(1, 0));
  endtask

  task automatic t_both;
    logic [31:0] v;
    int lat;
    loc_op(1'b1, 1'b1, 12'(12*4), 9'h000, 32'h0000_FFFF, v, lat);
    chk("R8 read performed", v, base_v(12));
    lrd("R8 write discarded", 12'(12*4), 9'h000, base_v(12));
  endtask

  task automatic t_pending;
    @(negedge clk);
    link_req = 1'b1; link_wr = 1'b0; link_addr = 12'd0; link_sel = 9'h000;
    loc_rd = 1'b1; loc_addr = 12'(10*4); loc_sel = 9'h000;
    @(negedge clk);
    loc_rd = 1'b0; loc_wr = 1'b1; loc_addr = 12'(11*4); loc_wdata = 32'h0000_7777;
    @(negedge clk);
    loc_wr = 1'b0;
    @(negedge clk);
    link_req = 1'b0;
    @(negedge clk);
    chk("R9 first request acked", 32'(loc_ack), 32'd1);
    chk("R9 first request data", loc_rdata, base_v(10));
    @(negedge clk);
    chk("R9 no second ack", 32'(loc_ack), 32'd0);
    @(negedge clk);
    chk("R9 no late ack", 32'(loc_ack), 32'd0);
    lrd("R9 dropped write", 12'(11*4), 9'h000, base_v(11));
  endtask

  initial begin
    rst_n = 1'b0;
    link_req = 1'b0; link_wr = 1'b0; link_addr = '0; link_sel = '0; link_wdata = '0;
    loc_rd = 1'b0; loc_wr = 1'b0; loc_addr = '0; loc_sel = '0; loc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask;
    t_addr_low;
    t_select;
    t_range;
    t_priority;
    t_link;
    t_both;
    t_pending;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule